// File: doc/BRIEF.md
# Configuration Access Port

This block is the host I/O window for the address/data method of reaching configuration space. Software first writes a 32-bit selector into the address port. That selector names an enable flag, a bus, a device, a function and a register dword. Software then reads or writes the four-byte data window. Each data-window access turns into one configuration request to downstream logic. The request carries the target fields, a Type 0 / Type 1 marker, byte enables and lane-placed write data. The port then waits for the downstream completion before it answers the host.

Host accesses use a simple valid/ready handshake. The port samples `io_valid` only while idle and answers with a single-cycle `io_ready`. Host data is right-justified on `io_wdata` and `io_rdata`. The port moves it to or from the addressed byte lanes in little-endian order. Size codes are: 0 byte, 1 word (16 bits), 2 dword, 3 invalid. With the default parameters the address port sits at I/O 0xCF8 and the data window spans 0xCFC to 0xCFF. The configuration registers themselves live outside this block.

Top module: `cfg_io_port`

## Requirements
- R1: After reset the selector register is zero, `io_ready` and `cfg_req_valid` are low, and a dword read of 0xCF8 returns 0x00000000.
- R2: A dword write to 0xCF8 replaces the whole selector. A dword read of 0xCF8 returns the stored value with bits [1:0] forced to zero.
- R3: The following accesses are unclaimed: any non-dword access to 0xCF8, any access to 0xCF9 to 0xCFB, a misaligned data-window access (word at an odd offset, dword at a non-zero offset), size code 3, and any other port. An unclaimed access changes no state, issues no request and returns 0xFFFFFFFF.
- R4: While selector bit 31 is 0, a data-window access issues no request. A read returns 0xFFFFFFFF and a write is dropped.
- R5: A request carries bus = selector[23:16], device = [15:11], function = [10:8] and register = [7:2].
- R6: `cfg_req_type1` is 0 when the bus is 0 and 1 for any other bus.
- R7: Byte enables are as follows. A byte access at 0xCFC+k sets bit k. A word access at 0xCFC gives 0011 and at 0xCFE gives 1100. A dword access at 0xCFC gives 1111.
- R8: For a write, host byte j is placed on lane k+j, where k is the offset inside the data window. Lanes that are not enabled carry zero.
- R9: For a read, downstream lane k+j is returned as host byte j, for each byte of the access size. Higher host bytes are zero.
- R10: `cfg_req_valid` stays high with stable fields until `cfg_done` is sampled. `io_ready` pulses for one cycle on the next cycle. Host accesses presented while a request is open are ignored.
- R11: An access that needs no request (R2, R3, R4) is answered with `io_ready` in the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_valid | input | 1 | Host access present (sampled when idle) |
| io_write | input | 1 | 1 = I/O write, 0 = I/O read |
| io_addr | input | IO_AW | I/O port address |
| io_size | input | 2 | 0 byte, 1 word, 2 dword, 3 invalid |
| io_wdata | input | 32 | Right-justified write data |
| io_ready | output | 1 | One-cycle completion pulse |
| io_rdata | output | 32 | Right-justified read data, valid with io_ready |
| cfg_req_valid | output | 1 | Configuration request open |
| cfg_req_write | output | 1 | Request is a write |
| cfg_req_type1 | output | 1 | 0 = Type 0 (bus 0), 1 = Type 1 |
| cfg_req_bus | output | 8 | Target bus |
| cfg_req_dev | output | 5 | Target device |
| cfg_req_func | output | 3 | Target function |
| cfg_req_reg | output | 6 | Target register dword index |
| cfg_req_be | output | 4 | Byte enables of the target dword |
| cfg_req_wdata | output | 32 | Lane-placed write data |
| cfg_done | input | 1 | Downstream completion |
| cfg_rdata | input | 32 | Lane-aligned read data, valid with cfg_done |

## Verification
The bench targets lane steering at all four offsets and all three sizes. It uses a downstream dword with a distinct value in every byte, so a port that shifts the wrong way or forgets to mask returns a visibly wrong byte. It also writes host data with junk in the unused upper bytes, so a missing lane mask leaks those bytes into the request.

Partial accesses to the selector port are tested because a sloppy decoder would let a word write overwrite the selector. Misaligned data accesses are tested because they would otherwise produce a request with a broken enable pattern.

A selector write issued while a request is still open is tested because a port that accepted it would corrupt the open request. Bus 0 against non-zero buses is tested because a swapped comparison marks the wrong request type.

// File: rtl/cfg_io_pkg.sv
// Shared constants and types for the configuration access port.
// Assumes a 32-bit data window split into four byte lanes.
package cfg_io_pkg;
    localparam int DW = 32;
    localparam int NB = DW / 8;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_BAD   = 2'd3
    } io_size_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_ADDR = 2'd1,
        ACC_DATA = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RESP = 2'd2
    } port_state_e;
endpackage

// File: rtl/cfg_io_decode.sv
// Classifies a host I/O access as a selector access, a data-window access
// or unclaimed. It also derives the lane offset and byte enables.
// Assumes DATA_PORT is dword aligned. Purely combinational.
module cfg_io_decode
    import cfg_io_pkg::*;
#(
    parameter int               IO_AW     = 16,
    parameter logic [IO_AW-1:0] ADDR_PORT = 'hCF8,
    parameter logic [IO_AW-1:0] DATA_PORT = 'hCFC
) (
    input  logic [IO_AW-1:0] io_addr,
    input  logic [1:0]       io_size,
    output acc_kind_e        kind,
    output logic [1:0]       lane_off,
    output logic [NB-1:0]    lane_be
);
    io_size_e sz;
    logic     aligned;
    logic     data_hit;

    assign sz       = io_size_e'(io_size);
    assign lane_off = io_addr[1:0];
    assign data_hit = (io_addr[IO_AW-1:2] == DATA_PORT[IO_AW-1:2]);

    // Alignment rule and byte-enable pattern per access size.
    always_comb begin
        aligned = 1'b0;
        lane_be = '0;
        case (sz)
            SZ_BYTE: begin
                aligned = 1'b1;
                lane_be = NB'(4'b0001 << lane_off);
            end
            SZ_WORD: begin
                aligned = ~lane_off[0];
                lane_be = NB'(4'b0011 << lane_off);
            end
            SZ_DWORD: begin
                aligned = (lane_off == 2'd0);
                lane_be = '1;
            end
            default: begin
                aligned = 1'b0;
                lane_be = '0;
            end
        endcase
    end

    // Access classification; the selector only answers to full dwords.
    always_comb begin
        if (io_addr == ADDR_PORT && sz == SZ_DWORD)
            kind = ACC_ADDR;
        else if (data_hit && aligned)
            kind = ACC_DATA;
        else
            kind = ACC_NONE;
    end
endmodule

// File: rtl/cfg_addr_reg.sv
// Holds the configuration selector (enable, bus, device, function, register).
// A write replaces every stored bit. Bits [1:0] are not stored and read as zero.
// Assumes the caller only raises wen for accepted full-dword selector writes.
module cfg_addr_reg
    import cfg_io_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wen,
    input  logic [DW-1:0] wdata,
    output logic          en,
    output logic [7:0]    bus,
    output logic [4:0]    dev,
    output logic [2:0]    func,
    output logic [5:0]    regn,
    output logic [DW-1:0] rd_val
);
    logic [DW-1:2] sel_q;

    // Selector storage with a full overwrite on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (wen)
            sel_q <= wdata[DW-1:2];
    end

    assign en     = sel_q[31];
    assign bus    = sel_q[23:16];
    assign dev    = sel_q[15:11];
    assign func   = sel_q[10:8];
    assign regn   = sel_q[7:2];
    assign rd_val = {sel_q, 2'b00};
endmodule

// File: rtl/cfg_lane_steer.sv
// Moves right-justified host data onto the addressed byte lanes and back,
// in little-endian order. Lanes outside the access are zeroed.
// Assumes the offset and size were already checked for alignment. Combinational.
module cfg_lane_steer
    import cfg_io_pkg::*;
(
    input  logic [1:0]    lane_off,
    input  logic [1:0]    io_size,
    input  logic [NB-1:0] lane_be,
    input  logic [DW-1:0] host_wdata,
    input  logic [DW-1:0] lane_rdata,
    output logic [DW-1:0] lane_wdata,
    output logic [DW-1:0] host_rdata
);
    logic [2:0] nbytes;

    // Number of host bytes carried by the access size.
    always_comb begin
        case (io_size_e'(io_size))
            SZ_BYTE:  nbytes = 3'd1;
            SZ_WORD:  nbytes = 3'd2;
            SZ_DWORD: nbytes = 3'd4;
            default:  nbytes = 3'd0;
        endcase
    end

    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic [1:0] wsrc;
        logic [1:0] rsrc;
        assign wsrc = 2'(i) - lane_off;
        assign rsrc = 2'(i) + lane_off;
        assign lane_wdata[8*i +: 8] = lane_be[i] ? host_wdata[{wsrc, 3'b000} +: 8] : 8'h00;
        assign host_rdata[8*i +: 8] = (3'(i) < nbytes) ? lane_rdata[{rsrc, 3'b000} +: 8] : 8'h00;
    end
endmodule

// File: rtl/cfg_io_port.sv
// Top of the configuration access port. It accepts one host I/O access at a
// time. Selector and unclaimed accesses are answered locally. Enabled
// data-window accesses become one configuration request, held until cfg_done.
// Assumes the host waits for io_ready before expecting the next access to count.
module cfg_io_port
    import cfg_io_pkg::*;
#(
    parameter int               IO_AW     = 16,
    parameter logic [IO_AW-1:0] ADDR_PORT = 'hCF8,
    parameter logic [IO_AW-1:0] DATA_PORT = 'hCFC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_valid,
    input  logic             io_write,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [1:0]       io_size,
    input  logic [31:0]      io_wdata,
    output logic             io_ready,
    output logic [31:0]      io_rdata,
    output logic             cfg_req_valid,
    output logic             cfg_req_write,
    output logic             cfg_req_type1,
    output logic [7:0]       cfg_req_bus,
    output logic [4:0]       cfg_req_dev,
    output logic [2:0]       cfg_req_func,
    output logic [5:0]       cfg_req_reg,
    output logic [3:0]       cfg_req_be,
    output logic [31:0]      cfg_req_wdata,
    input  logic             cfg_done,
    input  logic [31:0]      cfg_rdata
);
    port_state_e   state;
    acc_kind_e     kind;
    logic [1:0]    off;
    logic [NB-1:0] be;
    logic          accept;
    logic          sel_wen;
    logic          cfg_en;
    logic [7:0]    a_bus;
    logic [DW-1:0] a_rd;
    logic [DW-1:0] rd_just;

    logic [1:0]    off_q;
    logic [1:0]    size_q;
    logic [NB-1:0] be_q;
    logic          wr_q;
    logic          type1_q;
    logic [DW-1:0] wraw_q;
    logic [DW-1:0] rdata_q;

    cfg_io_decode #(
        .IO_AW    (IO_AW),
        .ADDR_PORT(ADDR_PORT),
        .DATA_PORT(DATA_PORT)
    ) u_decode (
        .io_addr (io_addr),
        .io_size (io_size),
        .kind    (kind),
        .lane_off(off),
        .lane_be (be)
    );

    assign accept  = io_valid && (state == ST_IDLE);
    assign sel_wen = accept && io_write && (kind == ACC_ADDR);

    cfg_addr_reg u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .wen   (sel_wen),
        .wdata (io_wdata),
        .en    (cfg_en),
        .bus   (a_bus),
        .dev   (cfg_req_dev),
        .func  (cfg_req_func),
        .regn  (cfg_req_reg),
        .rd_val(a_rd)
    );

    cfg_lane_steer u_steer (
        .lane_off  (off_q),
        .io_size   (size_q),
        .lane_be   (be_q),
        .host_wdata(wraw_q),
        .lane_rdata(cfg_rdata),
        .lane_wdata(cfg_req_wdata),
        .host_rdata(rd_just)
    );

    // Access sequencing: accept, optionally hold a request, then answer once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            off_q   <= '0;
            size_q  <= '0;
            be_q    <= '0;
            wr_q    <= 1'b0;
            type1_q <= 1'b0;
            wraw_q  <= '0;
            rdata_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (io_valid) begin
                        off_q   <= off;
                        size_q  <= io_size;
                        be_q    <= be;
                        wr_q    <= io_write;
                        wraw_q  <= io_wdata;
                        type1_q <= (a_bus != 8'h00);
                        if (kind == ACC_DATA && cfg_en) begin
                            state <= ST_REQ;
                        end else begin
                            state   <= ST_RESP;
                            rdata_q <= (kind == ACC_ADDR) ? a_rd : '1;
                        end
                    end
                end
                ST_REQ: begin
                    if (cfg_done) begin
                        rdata_q <= rd_just;
                        state   <= ST_RESP;
                    end
                end
                ST_RESP: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign io_ready      = (state == ST_RESP);
    assign io_rdata      = rdata_q;
    assign cfg_req_valid = (state == ST_REQ);
    assign cfg_req_write = wr_q;
    assign cfg_req_type1 = type1_q;
    assign cfg_req_bus   = a_bus;
    assign cfg_req_be    = be_q;
endmodule

// File: rtl/cfg_io_port_chk.sv
// Protocol checker for cfg_io_port, attached by bind. It watches the request
// handshake, the response pulse and the shape of each request.
module cfg_io_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        io_ready,
    input logic        cfg_req_valid,
    input logic        cfg_req_write,
    input logic        cfg_req_type1,
    input logic [7:0]  cfg_req_bus,
    input logic [4:0]  cfg_req_dev,
    input logic [2:0]  cfg_req_func,
    input logic [5:0]  cfg_req_reg,
    input logic [3:0]  cfg_req_be,
    input logic [31:0] cfg_req_wdata,
    input logic        cfg_done,
    input logic        cfg_en
);
    logic [31:0] be_mask;
    assign be_mask = {{8{cfg_req_be[3]}}, {8{cfg_req_be[2]}}, {8{cfg_req_be[1]}}, {8{cfg_req_be[0]}}};

    // R10: an open request keeps every field until it completes
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid && !cfg_done |=> cfg_req_valid && $stable(cfg_req_bus) &&
        $stable(cfg_req_dev) && $stable(cfg_req_func) && $stable(cfg_req_reg) &&
        $stable(cfg_req_be) && $stable(cfg_req_wdata) && $stable(cfg_req_write));

    // R10: completion answers the host on the next cycle
    p_done_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid && cfg_done |=> io_ready && !cfg_req_valid);

    // R10: the host response is a single-cycle pulse
    p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        io_ready |=> !io_ready);

    // R4: no request exists while the selector is disabled
    p_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |-> cfg_en);

    // R6: request type follows the bus number
    p_type_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |-> (cfg_req_type1 == (cfg_req_bus != 8'h00)));

    // R7: only legal aligned enable patterns appear
    p_be_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |-> (cfg_req_be inside {4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                              4'b0011, 4'b1100, 4'b1111}));

    // R8: disabled lanes of a write carry zero
    p_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid && cfg_req_write |-> ((cfg_req_wdata & ~be_mask) == 32'h0));
endmodule

bind cfg_io_port cfg_io_port_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_ready     (io_ready),
    .cfg_req_valid(cfg_req_valid),
    .cfg_req_write(cfg_req_write),
    .cfg_req_type1(cfg_req_type1),
    .cfg_req_bus  (cfg_req_bus),
    .cfg_req_dev  (cfg_req_dev),
    .cfg_req_func (cfg_req_func),
    .cfg_req_reg  (cfg_req_reg),
    .cfg_req_be   (cfg_req_be),
    .cfg_req_wdata(cfg_req_wdata),
    .cfg_done     (cfg_done),
    .cfg_en       (cfg_en)
);

// File: tb/cfg_io_port_tb.sv
`timescale 1ns/1ps
module cfg_io_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_valid = 1'b0;
    logic        io_write = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic [1:0]  io_size = 2'd0;
    logic [31:0] io_wdata = 32'h0;
    logic        io_ready;
    logic [31:0] io_rdata;
    logic        cfg_req_valid, cfg_req_write, cfg_req_type1;
    logic [7:0]  cfg_req_bus;
    logic [4:0]  cfg_req_dev;
    logic [2:0]  cfg_req_func;
    logic [5:0]  cfg_req_reg;
    logic [3:0]  cfg_req_be;
    logic [31:0] cfg_req_wdata;
    logic        cfg_done = 1'b0;
    logic [31:0] cfg_rdata = 32'h0;

    always #2 clk = ~clk;

    cfg_io_port u_dut (
        .clk(clk), .rst_n(rst_n),
        .io_valid(io_valid), .io_write(io_write), .io_addr(io_addr),
        .io_size(io_size), .io_wdata(io_wdata),
        .io_ready(io_ready), .io_rdata(io_rdata),
        .cfg_req_valid(cfg_req_valid), .cfg_req_write(cfg_req_write),
        .cfg_req_type1(cfg_req_type1), .cfg_req_bus(cfg_req_bus),
        .cfg_req_dev(cfg_req_dev), .cfg_req_func(cfg_req_func),
        .cfg_req_reg(cfg_req_reg), .cfg_req_be(cfg_req_be),
        .cfg_req_wdata(cfg_req_wdata),
        .cfg_done(cfg_done), .cfg_rdata(cfg_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Results of the last access
    logic [31:0] r_rd;
    int          r_lat;
    bit          r_saw, r_unstable, r_pulse_ok;
    logic [7:0]  s_bus; logic [4:0] s_dev; logic [2:0] s_func; logic [5:0] s_reg;
    logic        s_t1, s_wr; logic [3:0] s_be; logic [31:0] s_wd;

    // One host access with a downstream responder that completes after two request cycles
    task automatic access(input bit wr, input logic [15:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, input logic [31:0] resp);
        int vcnt;
        @(negedge clk);
        io_valid = 1'b1; io_write = wr; io_addr = a; io_size = sz; io_wdata = wd;
        @(negedge clk);
        io_valid = 1'b0;
        r_lat = 1; vcnt = 0; r_saw = 1'b0; r_unstable = 1'b0;
        while (!io_ready && r_lat < 50) begin
            if (cfg_req_valid) begin
                if (!r_saw) begin
                    r_saw = 1'b1;
                    s_bus = cfg_req_bus; s_dev = cfg_req_dev; s_func = cfg_req_func;
                    s_reg = cfg_req_reg; s_t1 = cfg_req_type1; s_wr = cfg_req_write;
                    s_be = cfg_req_be; s_wd = cfg_req_wdata;
                end else if ({s_bus, s_dev, s_func, s_reg, s_t1, s_wr, s_be, s_wd} !==
                             {cfg_req_bus, cfg_req_dev, cfg_req_func, cfg_req_reg,
                              cfg_req_type1, cfg_req_write, cfg_req_be, cfg_req_wdata}) begin
                    r_unstable = 1'b1;
                end
                vcnt++;
                if (vcnt == 2) begin
                    cfg_done = 1'b1;
                    cfg_rdata = resp;
                end
            end
            @(negedge clk);
            cfg_done = 1'b0;
            r_lat++;
        end
        r_rd = io_rdata;
        @(negedge clk);
        r_pulse_ok = !io_ready;
    endtask

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic [3:0]  be;
        logic [31:0] exp;
    } vec_t;

    localparam logic [31:0] DRD = 32'hA1B2C3D4;
    localparam vec_t VECS [0:11] = '{
        '{1'b0, 16'hCFC, 2'd0, 32'h0,        4'b0001, 32'h000000D4},
        '{1'b0, 16'hCFD, 2'd0, 32'h0,        4'b0010, 32'h000000C3},
        '{1'b0, 16'hCFE, 2'd0, 32'h0,        4'b0100, 32'h000000B2},
        '{1'b0, 16'hCFF, 2'd0, 32'h0,        4'b1000, 32'h000000A1},
        '{1'b0, 16'hCFC, 2'd1, 32'h0,        4'b0011, 32'h0000C3D4},
        '{1'b0, 16'hCFE, 2'd1, 32'h0,        4'b1100, 32'h0000A1B2},
        '{1'b0, 16'hCFC, 2'd2, 32'h0,        4'b1111, 32'hA1B2C3D4},
        '{1'b1, 16'hCFD, 2'd0, 32'hFFFFFF5A, 4'b0010, 32'h00005A00},
        '{1'b1, 16'hCFE, 2'd1, 32'h1234BEEF, 4'b1100, 32'hBEEF0000},
        '{1'b1, 16'hCFC, 2'd2, 32'h11223344, 4'b1111, 32'h11223344},
        '{1'b1, 16'hCFF, 2'd0, 32'h00000077, 4'b1000, 32'h77000000},
        '{1'b1, 16'hCFC, 2'd1, 32'hAAAA5566, 4'b0011, 32'h00005566}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 io_ready", {31'h0, io_ready}, 32'h0);
        chk("R1 cfg_req_valid", {31'h0, cfg_req_valid}, 32'h0);
        rst_n = 1'b1;
        access(1'b0, 16'hCF8, 2'd2, 32'h0, 32'h0);
        chk("R1 selector reset", r_rd, 32'h0);
        chk("R11 local latency", r_lat, 1);

        // R4: disabled selector
        access(1'b0, 16'hCFC, 2'd2, 32'h0, DRD);
        chk("R4 read ones", r_rd, 32'hFFFFFFFF);
        chk("R4 no request on read", {31'h0, r_saw}, 32'h0);
        access(1'b1, 16'hCFE, 2'd1, 32'h1234, DRD);
        chk("R4 no request on write", {31'h0, r_saw}, 32'h0);
        chk("R11 disabled latency", r_lat, 1);

        // R2: full replace, low bits read zero
        access(1'b1, 16'hCF8, 2'd2, 32'h80032A47, 32'h0);
        chk("R11 selector write latency", r_lat, 1);
        access(1'b0, 16'hCF8, 2'd2, 32'h0, 32'h0);
        chk("R2 readback", r_rd, 32'h80032A44);

        // R3: unclaimed accesses
        access(1'b1, 16'hCF8, 2'd1, 32'h0000, 32'h0);
        access(1'b1, 16'hCF8, 2'd0, 32'h00, 32'h0);
        access(1'b1, 16'hCF9, 2'd2, 32'h0, 32'h0);
        access(1'b0, 16'hCF8, 2'd2, 32'h0, 32'h0);
        chk("R3 partial selector write ignored", r_rd, 32'h80032A44);
        access(1'b0, 16'hCF8, 2'd0, 32'h0, 32'h0);
        chk("R3 byte selector read ones", r_rd, 32'hFFFFFFFF);
        access(1'b0, 16'hCFD, 2'd1, 32'h0, DRD);
        chk("R3 misaligned word ones", r_rd, 32'hFFFFFFFF);
        chk("R3 misaligned word no request", {31'h0, r_saw}, 32'h0);
        access(1'b0, 16'hCFE, 2'd2, 32'h0, DRD);
        chk("R3 misaligned dword no request", {31'h0, r_saw}, 32'h0);
        access(1'b1, 16'hCFC, 2'd3, 32'h0, DRD);
        chk("R3 size code 3 no request", {31'h0, r_saw}, 32'h0);
        access(1'b0, 16'h0CF4, 2'd2, 32'h0, DRD);
        chk("R3 other port ones", r_rd, 32'hFFFFFFFF);

        // Vector table: R5 R6 R7 R8 R9 R10
        for (int i = 0; i < 12; i++) begin
            access(VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].wdata, DRD);
            chk($sformatf("R10 request seen v%0d", i), {31'h0, r_saw}, 32'h1);
            chk($sformatf("R10 latency v%0d", i), r_lat, 3);
            chk($sformatf("R10 stable v%0d", i), {31'h0, r_unstable}, 32'h0);
            chk($sformatf("R10 pulse v%0d", i), {31'h0, r_pulse_ok}, 32'h1);
            chk($sformatf("R5 fields v%0d", i), {10'h0, s_bus, s_dev, s_func, s_reg},
                {10'h0, 8'h03, 5'd5, 3'd2, 6'h11});
            chk($sformatf("R6 type1 v%0d", i), {31'h0, s_t1}, 32'h1);
            chk($sformatf("R7 be v%0d", i), {28'h0, s_be}, {28'h0, VECS[i].be});
            chk($sformatf("R10 write flag v%0d", i), {31'h0, s_wr}, {31'h0, VECS[i].wr});
            if (VECS[i].wr)
                chk($sformatf("R8 wdata v%0d", i), s_wd, VECS[i].exp);
            else
                chk($sformatf("R9 rdata v%0d", i), r_rd, VECS[i].exp);
        end

        // R6: bus 0 gives Type 0
        access(1'b1, 16'hCF8, 2'd2, 32'h80000808, 32'h0);
        access(1'b0, 16'hCFC, 2'd2, 32'h0, DRD);
        chk("R6 bus0 type0", {31'h0, s_t1}, 32'h0);
        chk("R5 bus0 fields", {10'h0, s_bus, s_dev, s_func, s_reg}, {10'h0, 8'h00, 5'd1, 3'd0, 6'h02});

        // R5: all fields at their maximum
        access(1'b1, 16'hCF8, 2'd2, 32'h80FFFFFC, 32'h0);
        access(1'b0, 16'hCFC, 2'd0, 32'h0, DRD);
        chk("R5 max fields", {10'h0, s_bus, s_dev, s_func, s_reg}, {10'h0, 8'hFF, 5'h1F, 3'h7, 6'h3F});

        // R10: host access during an open request is ignored
        @(negedge clk);
        io_valid = 1'b1; io_write = 1'b0; io_addr = 16'hCFC; io_size = 2'd2;
        @(negedge clk);
        io_valid = 1'b0;
        chk("R10 request open", {31'h0, cfg_req_valid}, 32'h1);
        @(negedge clk);
        io_valid = 1'b1; io_write = 1'b1; io_addr = 16'hCF8; io_size = 2'd2; io_wdata = 32'h0;
        @(negedge clk);
        io_valid = 1'b0; cfg_done = 1'b1; cfg_rdata = 32'h0BADF00D;
        @(negedge clk);
        cfg_done = 1'b0;
        chk("R10 ready after done", {31'h0, io_ready}, 32'h1);
        chk("R9 busy read data", io_rdata, 32'h0BADF00D);
        access(1'b0, 16'hCF8, 2'd2, 32'h0, 32'h0);
        chk("R10 busy write ignored", r_rd, 32'h80FFFFFC);

        done_flag = 1'b1;
        report();
    end
endmodule